// File: doc/BRIEF.md
# Key-Updating 16-bit Adder

This block is the integer add/subtract stage of a 16-bit datapath that keeps its arithmetic status in a 16-bit condition-key register. Each accepted operation forms `opa + opb + carry_in` and registers the 16-bit result. The result's carry, zero and signed-order status are merged into the key register. An overflow produces a one-cycle exception pulse, which is registered together with the result. To subtract, the caller passes the one's complement of the subtrahend as `opb` and sets `carry_in`.

The operation rewrites only four key positions: bits 15, 13, 7 and 6 (mask 16'hA0C0). Every other key bit keeps its previous value, so status owned by other units survives an add. The less-than key reports the true sign of the exact sum rather than the raw sign bit. When the add overflows, it is therefore the inverse of the result's top bit. A whole-register write port lets the surrounding core save and restore the keys.

Top module: `key_adder16`

## Requirements
- R1: One cycle after an edge where `op_valid` is 1 and `key_load` is 0, `result` equals the low 16 bits of `opa + opb + carry_in`.
- R2: After such an operation, key bit 13 (link) equals the carry out of bit 15 of the 17-bit sum.
- R3: After such an operation, key bit 6 (equal) is 1 exactly when the 16-bit result is zero.
- R4: Overflow is present when `opa[15]` equals `opb[15]` and `result[15]` differs from `opa[15]`. `ovf_pulse` is 1 for exactly the cycle after an overflowing operation and 0 after any other edge.
- R5: After such an operation, key bit 7 (less-than) equals `result[15]` XOR overflow, i.e. it is 1 exactly when the exact signed sum is negative.
- R6: Each operation clears key bit 15. Key bits other than 15, 13, 7 and 6 keep their previous values.
- R7: On an edge where `op_valid` and `key_load` are both 0, `result` and `keys` hold and `ovf_pulse` is 0 afterwards.
- R8: On an edge where `key_load` is 1, `keys` takes `key_wdata` in full. Any operation presented in the same cycle is discarded: `result` holds and `ovf_pulse` is 0.
- R9: While `rst` is sampled high, `result`, `keys` and `ovf_pulse` become 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Perform an add this cycle |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand (complemented by caller for subtract) |
| carry_in | input | 1 | Carry into bit 0 |
| key_load | input | 1 | Overwrite the whole key register |
| key_wdata | input | 16 | Value written when `key_load` is 1 |
| result | output | 16 | Registered sum |
| keys | output | 16 | Condition-key register |
| ovf_pulse | output | 1 | One-cycle integer-overflow exception |

## Verification
Every key is registered in the same edge as the result, so a wrong carry, zero or sign evaluation shows up at `keys` one cycle after the operation. The check reloads the keys with a mixed pattern before each operation. An error in the merge mask therefore also appears in that cycle, as an unowned bit that changed or an owned bit that kept its stale value. A stuck or stretched exception pulse is visible one cycle later, when `ovf_pulse` must have dropped.

// File: rtl/key_adder16_pkg.sv
package key_adder16_pkg;
  localparam int KEY_W      = 16;
  localparam int CKEY_BIT   = 15;
  localparam int LINK_BIT   = 13;
  localparam int LT_BIT     = 7;
  localparam int EQ_BIT     = 6;
  localparam logic [KEY_W-1:0] OWNED_MASK =
      (KEY_W'(1) << CKEY_BIT) | (KEY_W'(1) << LINK_BIT) |
      (KEY_W'(1) << LT_BIT)   | (KEY_W'(1) << EQ_BIT);

  typedef struct packed {
    logic carry;
    logic zero;
    logic ovf;
    logic less;
  } ka_status_t;
endpackage

// File: rtl/ka_sum.sv
module ka_sum #(
  parameter int W      = 16,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  generate
    if (RIPPLE) begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = cin;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]   = a[i] ^ b[i] ^ cy[i];
        assign cy[i+1]  = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
      end
      assign cout = cy[W];
    end else begin : g_infer
      logic [W:0] wide;
      assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      assign sum  = wide[W-1:0];
      assign cout = wide[W];
    end
  endgenerate
endmodule

// File: rtl/ka_status.sv
module ka_status
  import key_adder16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] sum,
  input  logic         cout,
  output ka_status_t   st
);
  localparam int MSB = W - 1;
  logic same_sign;
  logic sign_flip;

  assign same_sign = ~(a[MSB] ^ b[MSB]);
  assign sign_flip = a[MSB] ^ sum[MSB];

  always_comb begin
    st.carry = cout;
    st.zero  = (sum == '0);
    st.ovf   = same_sign & sign_flip;
    // true sign of the exact sum: raw sign, corrected on overflow
    st.less  = sum[MSB] ^ (same_sign & sign_flip);
  end
endmodule

// File: rtl/ka_keyreg.sv
module ka_keyreg
  import key_adder16_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic             load,
  input  logic [KEY_W-1:0] load_data,
  input  ka_status_t       st,
  output logic [KEY_W-1:0] keys_q
);
  logic [KEY_W-1:0] fresh;
  logic [KEY_W-1:0] merged;

  always_comb begin
    fresh           = '0;
    fresh[LINK_BIT] = st.carry;
    fresh[LT_BIT]   = st.less;
    fresh[EQ_BIT]   = st.zero;
    merged          = (keys_q & ~OWNED_MASK) | fresh;
  end

  always_ff @(posedge clk) begin
    if (rst)       keys_q <= '0;
    else if (load) keys_q <= load_data;
    else if (upd)  keys_q <= merged;
  end
endmodule

// File: rtl/key_adder16.sv
module key_adder16
  import key_adder16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter bit RIPPLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              carry_in,
  input  logic              key_load,
  input  logic [KEY_W-1:0]  key_wdata,
  output logic [DATA_W-1:0] result,
  output logic [KEY_W-1:0]  keys,
  output logic              ovf_pulse
);
  logic [DATA_W-1:0] sum_w;
  logic              cout_w;
  ka_status_t        st_w;
  logic              fire;

  assign fire = op_valid & ~key_load;

  ka_sum #(.W(DATA_W), .RIPPLE(RIPPLE)) u_sum (
    .a(opa), .b(opb), .cin(carry_in), .sum(sum_w), .cout(cout_w)
  );

  ka_status #(.W(DATA_W)) u_status (
    .a(opa), .b(opb), .sum(sum_w), .cout(cout_w), .st(st_w)
  );

  ka_keyreg u_keys (
    .clk(clk), .rst(rst), .upd(fire), .load(key_load),
    .load_data(key_wdata), .st(st_w), .keys_q(keys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= fire & st_w.ovf;
      if (fire) result <= sum_w;
    end
  end
endmodule

// File: rtl/key_adder16_chk.sv
module key_adder16_chk
  import key_adder16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic              carry_in,
  input logic              key_load,
  input logic [KEY_W-1:0]  key_wdata,
  input logic [DATA_W-1:0] result,
  input logic [KEY_W-1:0]  keys,
  input logic              ovf_pulse
);
  logic [DATA_W:0] ref_sum;
  logic            did_op;
  logic            idle;
  assign ref_sum = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, carry_in};
  assign did_op  = op_valid & ~key_load;
  assign idle    = ~op_valid & ~key_load;

  // R1
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    did_op |=> result == $past(ref_sum[DATA_W-1:0]));
  // R2
  link_key_chk: assert property (@(posedge clk) disable iff (rst)
    did_op |=> keys[LINK_BIT] == $past(ref_sum[DATA_W]));
  // R3
  equal_key_chk: assert property (@(posedge clk) disable iff (rst)
    did_op |=> keys[EQ_BIT] == (result == '0));
  // R4
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> $past(did_op));
  // R6
  keep_unowned_chk: assert property (@(posedge clk) disable iff (rst)
    did_op |=> ((keys & ~OWNED_MASK) == ($past(keys) & ~OWNED_MASK)) && !keys[CKEY_BIT]);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    idle |=> $stable(keys) && $stable(result) && !ovf_pulse);
  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    key_load |=> keys == $past(key_wdata) && $stable(result) && !ovf_pulse);
endmodule

bind key_adder16 key_adder16_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .opa(opa), .opb(opb),
  .carry_in(carry_in), .key_load(key_load), .key_wdata(key_wdata),
  .result(result), .keys(keys), .ovf_pulse(ovf_pulse)
);

// File: tb/tb_key_adder16.sv
module tb_key_adder16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic        carry_in = 1'b0;
  logic        key_load = 1'b0;
  logic [15:0] key_wdata = '0;
  logic [15:0] result, keys;
  logic        ovf_pulse;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  key_adder16 dut (.*);

  // {opa, opb, carry_in}
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {16'h0001, 16'h0002, 1'b0}, {16'hFFFF, 16'h0001, 1'b0},
    {16'h7FFF, 16'h0001, 1'b0}, {16'h8000, 16'hFFFF, 1'b0},
    {16'h0005, 16'hFFFA, 1'b1}, {16'h0003, 16'hFFFA, 1'b1},
    {16'h8000, 16'h8000, 1'b0}, {16'h1234, 16'h0000, 1'b1},
    {16'h7FFF, 16'h0000, 1'b1}, {16'hFFFF, 16'hFFFF, 1'b1},
    {16'h8000, 16'h7FFF, 1'b1}, {16'hC000, 16'hBFFF, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model from the requirements: exact integer arithmetic
  task automatic model(input logic [15:0] a, input logic [15:0] b, input logic c,
                       input logic [15:0] pre, output logic [15:0] er,
                       output logic [15:0] ek, output logic eo);
    int s, u;
    s  = int'($signed(a)) + int'($signed(b)) + int'(c);
    u  = int'(a) + int'(b) + int'(c);
    er = u[15:0];
    eo = (s > 32767) || (s < -32768);
    ek = pre & 16'h5F3F;
    ek[13] = (u > 65535);
    ek[7]  = (s < 0);
    ek[6]  = (er == 16'h0000);
  endtask

  initial begin
    logic [15:0] er, ek, held_r, held_k;
    logic eo;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset result", result, 16'h0);
    chk("R9 reset keys", keys, 16'h0);
    chk("R9 reset pulse", {15'b0, ovf_pulse}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] pre;
      pre = (i % 2 == 1) ? 16'hFFFF : 16'h1A35;
      key_load = 1'b1; key_wdata = pre;
      @(negedge clk);
      chk("R8 key write", keys, pre);
      key_load = 1'b0;
      op_valid = 1'b1;
      {opa, opb, carry_in} = VEC[i];
      @(negedge clk);
      op_valid = 1'b0;
      model(VEC[i][32:17], VEC[i][16:1], VEC[i][0], pre, er, ek, eo);
      chk("R1 sum", result, er);
      chk("R2 R3 R5 R6 keys", keys, ek);
      chk("R4 pulse", {15'b0, ovf_pulse}, {15'b0, eo});
      @(negedge clk);
      chk("R4 pulse one cycle", {15'b0, ovf_pulse}, 16'h0);
    end

    // R7: idle cycles with changing operands
    held_r = result; held_k = keys;
    opa = 16'h7FFF; opb = 16'h7FFF; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 idle result", result, held_r);
    chk("R7 idle keys", keys, held_k);
    chk("R7 idle pulse", {15'b0, ovf_pulse}, 16'h0);

    // R8: load beats an overflowing operation in the same cycle
    op_valid = 1'b1; key_load = 1'b1; key_wdata = 16'h0C3A;
    @(negedge clk);
    op_valid = 1'b0; key_load = 1'b0;
    chk("R8 load keys", keys, 16'h0C3A);
    chk("R8 result held", result, held_r);
    chk("R8 no pulse", {15'b0, ovf_pulse}, 16'h0);

    // R4: back-to-back overflows keep the pulse high each cycle
    op_valid = 1'b1; opa = 16'h7FFF; opb = 16'h0001; carry_in = 1'b0;
    @(negedge clk);
    chk("R4 first ovf", {15'b0, ovf_pulse}, 16'h1);
    opa = 16'h8000; opb = 16'h8000;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R4 second ovf", {15'b0, ovf_pulse}, 16'h1);
    chk("R5 less on neg ovf", {15'b0, keys[7]}, 16'h1);
    @(negedge clk);
    chk("R4 drop", {15'b0, ovf_pulse}, 16'h0);

    // R9: mid-run reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 rerun keys", keys, 16'h0);
    chk("R9 rerun result", result, 16'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule